// File: doc/BRIEF.md
# Serial Storage Link Power Wake Controller

This block sits on the host side of a serial storage link and keeps track of the link's power state: active, partial or slumber. The host only ever responds to low-power changes. The attached device asks for partial or slumber, and the block acknowledges every such request. The block never starts a low-power transition on its own.

When the host needs the cable while the link is asleep, the block holds the host operation back. It sends a wake out-of-band strobe and waits until the link reports ready. Only then does it grant the operation. A device wake brings the link straight back to active. If the link never becomes ready, a programmable timeout raises a wake error and retries the wake.

The control is a four-state machine: ACTIVE, PARTIAL, SLUMBER and WAKING. Its transitions are:

- ACTIVE→PARTIAL / ACTIVE→SLUMBER when the link is idle and a request, or a deferred one, is present.
- PARTIAL↔SLUMBER when a new request arrives in a low-power state.
- PARTIAL/SLUMBER→WAKING when a host operation is requested.
- PARTIAL/SLUMBER→ACTIVE when the device wakes the link.
- WAKING→ACTIVE when the link reports ready.
- WAKING→WAKING with a fresh wake strobe on timeout.

Top module: `link_wake_ctrl`

## Requirements
- R1: `link_state` encodes the state as 00 ACTIVE, 01 PARTIAL, 10 SLUMBER and 11 WAKING. After reset the state is ACTIVE and `lp_ack`, `comwake`, `op_gnt` and `wake_err` are all low.
- R2: Every cycle with `lp_req_vld` high is followed, in the next cycle, by `lp_ack` high, whatever the state.
- R3: A request seen in ACTIVE with `op_req` and `op_gnt` both low moves the link, next cycle, to SLUMBER if `lp_req_slumber` is 1 or to PARTIAL if it is 0. A request seen in PARTIAL or SLUMBER, with no `op_req` and no `dev_wake`, moves the link to the requested type.
- R4: In ACTIVE, `op_gnt` equals the previous cycle's `op_req`, and no `comwake` is produced. A request in ACTIVE is therefore granted in the next cycle.
- R5: `op_req` seen in PARTIAL or SLUMBER moves the link to WAKING next cycle, with `comwake` high for that one cycle. `op_gnt` stays low until `link_rdy` is seen in WAKING. The next cycle is then ACTIVE, with `op_gnt` equal to `op_req`.
- R6: With `wake_tmo` nonzero, if `link_rdy` is not seen for `wake_tmo` cycles after a `comwake` pulse, then `comwake` pulses again and `wake_err` goes high. `wake_err` stays high until `link_rdy` is seen in WAKING. A `wake_tmo` of 0 disables the timeout.
- R7: `dev_wake` seen in PARTIAL or SLUMBER without `op_req` moves the link to ACTIVE next cycle, with no `comwake`.
- R8: Some requests are acknowledged but deferred: those arriving while `op_req` or `op_gnt` is high, during WAKING, or together with a wake event in a low-power state. A deferred request takes effect once the link is ACTIVE with `op_req` and `op_gnt` both low. A newer request replaces an older deferred one.
- R9: `dev_wake` has no effect in ACTIVE or WAKING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_req_vld | input | 1 | Device low-power request strobe |
| lp_req_slumber | input | 1 | Request type: 1 slumber, 0 partial |
| dev_wake | input | 1 | Device woke the link |
| link_rdy | input | 1 | Link reports ready after a wake |
| op_req | input | 1 | Host operation request, held for the operation's length |
| wake_tmo | input | TMO_W | Wake timeout in cycles, 0 disables |
| lp_ack | output | 1 | Acknowledge strobe to the device |
| comwake | output | 1 | Wake out-of-band strobe |
| op_gnt | output | 1 | Host operation grant |
| wake_err | output | 1 | Wake timeout error flag |
| link_state | output | 2 | Current link state (R1 encoding) |

## Verification
The bench targets several corner cases:

- A request that arrives while an operation is granted. A design that switched state at once would drop the link under a live grant. One that forgot the request would never sleep afterwards.
- `link_rdy` arriving right at the timeout cycle, and timeouts that repeat. An off-by-one counter shifts the repeated wake strobe.
- A device wake and a host request in the same low-power cycle. A wrong priority either skips the wake strobe or grants on a sleeping link.
- Long random runs with both a short and a disabled timeout, checked against an independent cycle model.

// File: rtl/link_wake_pkg.sv
package link_wake_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_SLUMBER = 2'd2,
        ST_WAKE    = 2'd3
    } lnk_st_e;
endpackage

// File: rtl/lp_req_tracker.sv
module lp_req_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic req_vld,
    input  logic req_slumber,
    input  logic store,
    input  logic clear,
    output logic ack,
    output logic dfr_vld,
    output logic dfr_slumber
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack         <= 1'b0;
            dfr_vld     <= 1'b0;
            dfr_slumber <= 1'b0;
        end else begin
            ack <= req_vld;
            if (store) begin
                dfr_vld     <= 1'b1;
                dfr_slumber <= req_slumber;
            end else if (clear) begin
                dfr_vld <= 1'b0;
            end
        end
    end

    // R8
    dfr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dfr_vld && !store && !clear) |=> dfr_vld);
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;

    assign expired = run && (limit != '0) && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || expired) cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/link_wake_ctrl.sv
module link_wake_ctrl
    import link_wake_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lp_req_vld,
    input  logic             lp_req_slumber,
    input  logic             dev_wake,
    input  logic             link_rdy,
    input  logic             op_req,
    input  logic [TMO_W-1:0] wake_tmo,
    output logic             lp_ack,
    output logic             comwake,
    output logic             op_gnt,
    output logic             wake_err,
    output logic [1:0]       link_state
);
    lnk_st_e state_q, state_d;
    logic    gnt_q, cw_q, err_q;
    logic    store, clear, wake_start, expired, dfr_vld, dfr_slumber, idle;
    lnk_st_e tgt_new, tgt_dfr;

    assign idle    = !op_req && !gnt_q;
    assign tgt_new = lp_req_slumber ? ST_SLUMBER : ST_PARTIAL;
    assign tgt_dfr = dfr_slumber    ? ST_SLUMBER : ST_PARTIAL;

    lp_req_tracker u_trk (
        .clk(clk), .rst_n(rst_n), .req_vld(lp_req_vld), .req_slumber(lp_req_slumber),
        .store(store), .clear(clear), .ack(lp_ack), .dfr_vld(dfr_vld),
        .dfr_slumber(dfr_slumber)
    );

    wake_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_WAKE),
        .limit(wake_tmo), .expired(expired)
    );

    // next-state decision
    always_comb begin
        state_d    = state_q;
        store      = 1'b0;
        clear      = 1'b0;
        wake_start = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                if (!idle) begin
                    store = lp_req_vld;
                end else if (lp_req_vld) begin
                    state_d = tgt_new;
                    clear   = 1'b1;
                end else if (dfr_vld) begin
                    state_d = tgt_dfr;
                    clear   = 1'b1;
                end
            end
            ST_PARTIAL, ST_SLUMBER: begin
                if (op_req) begin
                    state_d    = ST_WAKE;
                    wake_start = 1'b1;
                    store      = lp_req_vld;
                end else if (dev_wake) begin
                    state_d = ST_ACTIVE;
                    store   = lp_req_vld;
                end else if (lp_req_vld) begin
                    state_d = tgt_new;
                    clear   = 1'b1;
                end
            end
            ST_WAKE: begin
                store = lp_req_vld;
                if (link_rdy) state_d = ST_ACTIVE;
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q <= 1'b0;
            cw_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            cw_q  <= wake_start || (state_q == ST_WAKE && expired && !link_rdy);
            gnt_q <= (state_q == ST_ACTIVE || (state_q == ST_WAKE && link_rdy)) ? op_req : 1'b0;
            if (state_q == ST_WAKE && link_rdy)    err_q <= 1'b0;
            else if (state_q == ST_WAKE && expired) err_q <= 1'b1;
        end
    end

    assign op_gnt     = gnt_q;
    assign comwake    = cw_q;
    assign wake_err   = err_q;
    assign link_state = state_q;

    // R2
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lp_req_vld |=> lp_ack);
    // R5
    gnt_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_gnt |-> (link_state == ST_ACTIVE));
    // R5
    cw_in_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        comwake |-> (link_state == ST_WAKE));
    // R8
    busy_holds_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == ST_ACTIVE && (op_req || op_gnt)) |=> (link_state == ST_ACTIVE));
    // R6
    err_rise_cw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_err) |-> comwake);
    // R7
    dev_wake_no_cw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_state == ST_PARTIAL || link_state == ST_SLUMBER) && dev_wake && !op_req)
        |=> (link_state == ST_ACTIVE && !comwake));
endmodule

// File: tb/link_wake_ctrl_bench.sv
module link_wake_ctrl_bench;
    localparam int TW = 8;
    logic clk = 1'b0, rst_n = 1'b0;
    logic lp_req_vld = 0, lp_req_slumber = 0, dev_wake = 0, link_rdy = 0, op_req = 0;
    logic [TW-1:0] wake_tmo = '0;
    logic lp_ack, comwake, op_gnt, wake_err;
    logic [1:0] link_state;

    int checks = 0, errors = 0;

    // model state (R1 encoding)
    logic [1:0] m_st; logic m_ack, m_cw, m_gnt, m_err, m_dv, m_ds; int m_cnt;

    always #5 clk = ~clk;

    link_wake_ctrl #(.TMO_W(TW)) u_link_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .lp_req_vld(lp_req_vld), .lp_req_slumber(lp_req_slumber),
        .dev_wake(dev_wake), .link_rdy(link_rdy), .op_req(op_req), .wake_tmo(wake_tmo),
        .lp_ack(lp_ack), .comwake(comwake), .op_gnt(op_gnt), .wake_err(wake_err),
        .link_state(link_state)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] tgt(input logic slp);
        return slp ? 2'd2 : 2'd1;
    endfunction

    task automatic model_reset();
        m_st = 0; m_ack = 0; m_cw = 0; m_gnt = 0; m_err = 0; m_dv = 0; m_ds = 0; m_cnt = 0;
    endtask

    task automatic model_step();
        logic [1:0] n_st = m_st; logic n_cw = 0, n_gnt = 0, n_err = m_err;
        logic n_dv = m_dv, n_ds = m_ds; int n_cnt = 0;
        logic idle = !op_req && !m_gnt;
        logic tmo_hit = (wake_tmo != 0) && (m_cnt == int'(wake_tmo) - 1);
        logic dfr = 0;
        case (m_st)
            2'd0: begin
                n_gnt = op_req;
                if (!idle) dfr = lp_req_vld;
                else if (lp_req_vld) begin n_st = tgt(lp_req_slumber); n_dv = 0; end
                else if (m_dv) begin n_st = tgt(m_ds); n_dv = 0; end
            end
            2'd1, 2'd2: begin
                if (op_req) begin n_st = 3; n_cw = 1; dfr = lp_req_vld; end
                else if (dev_wake) begin n_st = 0; dfr = lp_req_vld; end
                else if (lp_req_vld) n_st = tgt(lp_req_slumber);
            end
            default: begin
                dfr = lp_req_vld;
                if (link_rdy) begin n_st = 0; n_gnt = op_req; n_err = 0; end
                else if (tmo_hit) begin n_cw = 1; n_err = 1; end
                n_cnt = tmo_hit ? 0 : m_cnt + 1;
            end
        endcase
        if (dfr) begin n_dv = 1; n_ds = lp_req_slumber; end
        m_ack = lp_req_vld; m_st = n_st; m_cw = n_cw; m_gnt = n_gnt; m_err = n_err;
        m_dv = n_dv; m_ds = n_ds; m_cnt = n_cnt;
    endtask

    task automatic compare_all();
        check("R1", "link_state", link_state, m_st);
        check("R2", "lp_ack", lp_ack, m_ack);
        check("R5", "comwake", comwake, m_cw);
        check("R4", "op_gnt", op_gnt, m_gnt);
        check("R6", "wake_err", wake_err, m_err);
    endtask

    // inputs are set before this call, away from the edge; sample 1 ns after the edge
    task automatic cycle();
        model_step();
        @(posedge clk); #1;
        compare_all();
        #3;
    endtask

    task automatic drive(logic lp, logic slp, logic dw, logic rdy, logic op);
        lp_req_vld = lp; lp_req_slumber = slp; dev_wake = dw; link_rdy = rdy; op_req = op;
    endtask

    task automatic do_reset();
        drive(0, 0, 0, 0, 0);
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1; rst_n = 1; model_reset(); #3;
    endtask

    task automatic random_run(int n, int rdy_pct);
        for (int i = 0; i < n; i++) begin
            logic op = op_req;
            if ($urandom_range(99) < 12) op = ~op;
            drive($urandom_range(99) < 15, $urandom_range(1), $urandom_range(99) < 10,
                  $urandom_range(99) < rdy_pct, op);
            cycle();
        end
    endtask

    initial begin
        void'($urandom(32'h5A17));
        wake_tmo = 8'd3;
        do_reset();
        // R1 reset state
        check("R1", "reset state", link_state, 0);
        check("R1", "reset outs", {lp_ack, comwake, op_gnt, wake_err}, 0);

        // R3 idle slumber request
        drive(1, 1, 0, 0, 0); cycle();
        check("R3", "enter slumber", link_state, 2);
        check("R2", "ack", lp_ack, 1);
        // R3 type change in low power
        drive(1, 0, 0, 0, 0); cycle();
        check("R3", "slumber->partial", link_state, 1);
        // R5 host op wakes link
        drive(0, 0, 0, 0, 1); cycle();
        check("R5", "waking", link_state, 3);
        check("R5", "comwake pulse", comwake, 1);
        drive(0, 0, 0, 0, 1); cycle();
        check("R5", "no grant before ready", op_gnt, 0);
        check("R5", "single pulse", comwake, 0);
        drive(0, 0, 0, 1, 1); cycle();
        check("R5", "grant after ready", op_gnt, 1);
        check("R5", "active", link_state, 0);
        // R8 request during grant deferred
        drive(1, 0, 0, 0, 1); cycle();
        check("R8", "stay active", link_state, 0);
        check("R2", "ack while busy", lp_ack, 1);
        drive(0, 0, 0, 0, 0); cycle();
        check("R4", "grant drops", op_gnt, 0);
        check("R8", "still active", link_state, 0);
        drive(0, 0, 0, 0, 0); cycle();
        check("R8", "deferred applied", link_state, 1);
        // R7 device wake
        drive(0, 0, 1, 0, 0); cycle();
        check("R7", "dev wake active", link_state, 0);
        check("R7", "no comwake", comwake, 0);
        // R9 dev wake ignored in active
        drive(0, 0, 1, 0, 0); cycle();
        check("R9", "ignored in active", link_state, 0);
        // R4 direct grant
        drive(0, 0, 0, 0, 1); cycle();
        check("R4", "grant next cycle", op_gnt, 1);
        check("R4", "no wake", comwake, 0);
        drive(0, 0, 0, 0, 0); cycle(); cycle();
        // R6 timeout with wake_tmo=3
        drive(1, 1, 0, 0, 0); cycle();
        drive(0, 0, 0, 0, 1); cycle();
        check("R6", "first pulse", comwake, 1);
        drive(0, 0, 1, 0, 1); cycle();
        check("R9", "dev wake ignored waking", link_state, 3);
        drive(0, 0, 0, 0, 1); cycle();
        check("R6", "no early retry", comwake, 0);
        cycle();
        check("R6", "retry pulse", comwake, 1);
        check("R6", "error set", wake_err, 1);
        drive(0, 0, 0, 1, 1); cycle();
        check("R6", "error cleared", wake_err, 0);
        check("R5", "grant", op_gnt, 1);

        random_run(4000, 30);
        random_run(2000, 4);
        wake_tmo = '0;
        do_reset();
        // R6 disabled timeout
        drive(1, 0, 0, 0, 0); cycle();
        drive(0, 0, 0, 0, 1); cycle();
        drive(0, 0, 0, 0, 1);
        for (int i = 0; i < 300; i++) cycle();
        check("R6", "disabled: no error", wake_err, 0);
        check("R6", "disabled: no retry", comwake, 0);
        random_run(3000, 5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule